// File: doc/BRIEF.md
# RTC Periodic and Alarm Interrupt Generator

This block turns the rollover strobes of a real-time-clock calendar into one active-high interrupt request. The calendar supplies single-cycle pulses when its seconds, minutes, hours and days counters roll over. It also supplies a single-cycle pulse when its time matches a programmed alarm. A two-bit select chooses which of the four rollovers drives the periodic interrupt. A separate enable gates the alarm interrupt.

Each interrupt source has a sticky flag. A flag sets when its gated event arrives and holds until software writes 1 to its bit in the status register. The interrupt line is high while either flag is set. Software reaches both registers through a small byte-wide port. Writes take effect at the clock edge. Reads are combinational from the address.

Each flag is a two-state machine with states FLG_IDLE and FLG_PEND. The transition IDLE_TO_PEND happens on a gated event. The transition PEND_TO_IDLE happens on a clear write that arrives without an event in the same cycle. The hold transitions IDLE_STAY and PEND_STAY cover every other case.

Top module: `rtc_irq_gen`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the status register (address 1) reads 0x00 and `irq` is 0.
- R2: The control register is at address 0. Bit 3 is the alarm enable, bit 2 is the periodic enable and bits 1:0 are the period select. All three fields read back what was written. Bits 7:4 always read 0 and ignore writes.
- R3: With the periodic enable at 1, a pulse on the selected strobe sets the timer flag (status bit 0) at that clock edge. Select 00 picks `sec_tick`, 01 picks `min_tick`, 10 picks `hour_tick` and 11 picks `day_tick`. Pulses on the other three strobes have no effect.
- R4: With the periodic enable at 0, no rollover strobe sets the timer flag.
- R5: A pulse on `alarm_hit` sets the alarm flag (status bit 1) only when the alarm enable is 1. When the alarm enable is 0, the pulse is ignored.
- R6: `irq` is 1 in every cycle in which at least one status flag is set, and 0 otherwise.
- R7: Writing to address 1 clears each flag whose bit in the written byte is 1 and leaves the other flags unchanged. Status bits 7:2 read 0.
- R8: If a flag's event and a clear write for that flag arrive in the same cycle, the flag ends up set.
- R9: A strobe that arrives in the same cycle as a control write is judged against the old control value. Later strobes use the new value. A control write never sets a flag by itself.
- R10: Addresses 2 and 3 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | Seconds rollover strobe |
| min_tick | input | 1 | Minutes rollover strobe |
| hour_tick | input | 1 | Hours rollover strobe |
| day_tick | input | 1 | Days rollover strobe |
| alarm_hit | input | 1 | Alarm match strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a strobe arriving together with a control write that changes the select. The other is an event arriving together with the clear write for its own flag. Both decide which of two register updates wins at a single edge. The bench uses one drive task that sets the write strobe and the event inputs in the same low phase of the clock. This places both on exactly the same edge. The status register is then read in the following cycle to see which update won.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int DATA_W = 8;

    localparam int CTRL_ADDR = 0;
    localparam int STAT_ADDR = 1;

    localparam int CTRL_ALM_BIT = 3;
    localparam int CTRL_PER_BIT = 2;

    localparam int STAT_TMR_BIT = 0;
    localparam int STAT_ALM_BIT = 1;

    typedef enum logic [1:0] {
        PER_SEC  = 2'b00,
        PER_MIN  = 2'b01,
        PER_HOUR = 2'b10,
        PER_DAY  = 2'b11
    } per_sel_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic     alm_en;
        logic     per_en;
        per_sel_e per_sel;
    } ctrl_t;

endpackage

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CTRL_ADDR);

    logic hit;

    assign hit = wr_en && (addr == MY_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl.alm_en  <= 1'b0;
            ctrl.per_en  <= 1'b0;
            ctrl.per_sel <= PER_SEC;
        end else if (hit) begin
            ctrl.alm_en  <= wdata[CTRL_ALM_BIT];
            ctrl.per_en  <= wdata[CTRL_PER_BIT];
            ctrl.per_sel <= per_sel_e'(wdata[1:0]);
        end
    end

endmodule

// File: rtl/rtc_irq_period_sel.sv
module rtc_irq_period_sel
    import rtc_irq_pkg::*;
(
    input  per_sel_e sel,
    input  logic     enable,
    input  logic     sec_tick,
    input  logic     min_tick,
    input  logic     hour_tick,
    input  logic     day_tick,
    output logic     event_o
);

    logic picked;

    always_comb begin
        unique case (sel)
            PER_SEC:  picked = sec_tick;
            PER_MIN:  picked = min_tick;
            PER_HOUR: picked = hour_tick;
            PER_DAY:  picked = day_tick;
            default:  picked = 1'b0;
        endcase
    end

    assign event_o = enable && picked;

endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set_i) state_d = FLG_PEND;
            FLG_PEND: if (clr_i && !set_i) state_d = FLG_IDLE;
            default:  state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == FLG_PEND);
    end

endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen
    import rtc_irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              min_tick,
    input  logic              hour_tick,
    input  logic              day_tick,
    input  logic              alarm_hit,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);

    localparam int NUM_FLAGS = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    ctrl_t                ctrl;
    logic                 per_event;
    logic                 alm_event;
    logic                 stat_wr;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_pend;

    rtc_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    rtc_irq_period_sel u_psel (
        .sel       (ctrl.per_sel),
        .enable    (ctrl.per_en),
        .sec_tick  (sec_tick),
        .min_tick  (min_tick),
        .hour_tick (hour_tick),
        .day_tick  (day_tick),
        .event_o   (per_event)
    );

    assign alm_event = ctrl.alm_en && alarm_hit;
    assign stat_wr   = reg_wr && (reg_addr == A_STAT);

    assign flag_set[STAT_TMR_BIT] = per_event;
    assign flag_set[STAT_ALM_BIT] = alm_event;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        assign flag_clr[g] = stat_wr && reg_wdata[g];
        rtc_irq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .clr_i  (flag_clr[g]),
            .pend_o (flag_pend[g])
        );
    end

    assign irq = |flag_pend;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata[CTRL_ALM_BIT] = ctrl.alm_en;
            reg_rdata[CTRL_PER_BIT] = ctrl.per_en;
            reg_rdata[1:0]          = ctrl.per_sel;
        end else if (reg_addr == A_STAT) begin
            reg_rdata[NUM_FLAGS-1:0] = flag_pend;
        end
    end

endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk #(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alarm_hit,
    input logic              alm_en,
    input logic              per_en,
    input logic              tmr_pend,
    input logic              alm_pend,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              irq
);

    logic clr_tmr;
    logic clr_alm;

    assign clr_tmr = reg_wr && (reg_addr == ADDR_W'(1)) && reg_wdata[0];
    assign clr_alm = reg_wr && (reg_addr == ADDR_W'(1)) && reg_wdata[1];

    assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(0)) |-> (reg_rdata[7:4] == 4'h0));

    assert_no_timer_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_en && !tmr_pend) |=> !tmr_pend);

    assert_alarm_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_en && !alm_pend) |=> !alm_pend);

    assert_alarm_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_en && alarm_hit) |=> irq);

    assert_timer_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_pend && !clr_tmr) |=> tmr_pend);

    assert_alarm_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_pend && !clr_alm) |=> alm_pend);

endmodule

bind rtc_irq_gen rtc_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alarm_hit (alarm_hit),
    .alm_en    (ctrl.alm_en),
    .per_en    (ctrl.per_en),
    .tmr_pend  (flag_pend[0]),
    .alm_pend  (flag_pend[1]),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
);

// File: tb/tb_rtc_irq_gen.sv
module tb_rtc_irq_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ticks = 4'h0;
    logic       alarm_hit = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_irq_gen #(.ADDR_W(2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (ticks[0]),
        .min_tick  (ticks[1]),
        .hour_tick (ticks[2]),
        .day_tick  (ticks[3]),
        .alarm_hit (alarm_hit),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, applied in the low phase so that it lands on one edge.
    task automatic drive(input logic wr, input logic [1:0] addr, input logic [7:0] data,
                         input logic [3:0] tk, input logic alm);
        @(negedge clk);
        reg_wr = wr; reg_addr = addr; reg_wdata = data; ticks = tk; alarm_hit = alm;
        @(negedge clk);
        reg_wr = 1'b0; ticks = 4'h0; alarm_hit = 1'b0;
    endtask

    task automatic rd(input logic [1:0] addr, output logic [7:0] val);
        reg_addr = addr;
        #1;
        val = reg_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [1:0] addr, input logic [7:0] exp);
        logic [7:0] v;
        rd(addr, v);
        check(req, v, exp);
    endtask

    task automatic test_reset();
        expect_reg("R1 ctrl", 2'd0, 8'h00);
        expect_reg("R1 status", 2'd1, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic test_ctrl_rw();
        drive(1'b1, 2'd0, 8'hFF, 4'h0, 1'b0);
        expect_reg("R2 upper bits zero", 2'd0, 8'h0F);
        drive(1'b1, 2'd0, 8'hA6, 4'h0, 1'b0);
        expect_reg("R2 field readback", 2'd0, 8'h06);
        drive(1'b1, 2'd0, 8'h00, 4'h0, 1'b0);
        expect_reg("R2 cleared", 2'd0, 8'h00);
    endtask

    task automatic test_periodic();
        for (int s = 0; s < 4; s++) begin
            drive(1'b1, 2'd0, 8'h04 | 8'(s), 4'h0, 1'b0);
            for (int t = 0; t < 4; t++) begin
                if (t != s) drive(1'b0, 2'd0, 8'h00, 4'(1 << t), 1'b0);
            end
            expect_reg("R3 other strobes ignored", 2'd1, 8'h00);
            drive(1'b0, 2'd0, 8'h00, 4'(1 << s), 1'b0);
            expect_reg("R3 selected strobe sets flag", 2'd1, 8'h01);
            check("R6 irq with timer flag", {7'd0, irq}, 8'h01);
            drive(1'b1, 2'd1, 8'h01, 4'h0, 1'b0);
            expect_reg("R7 timer clear", 2'd1, 8'h00);
            check("R6 irq low after clear", {7'd0, irq}, 8'h00);
        end
    endtask

    task automatic test_disabled();
        drive(1'b1, 2'd0, 8'h00, 4'h0, 1'b0);
        drive(1'b0, 2'd0, 8'h00, 4'hF, 1'b0);
        expect_reg("R4 periodic disabled", 2'd1, 8'h00);
        check("R4 irq stays low", {7'd0, irq}, 8'h00);
    endtask

    task automatic test_alarm();
        drive(1'b0, 2'd0, 8'h00, 4'h0, 1'b1);
        expect_reg("R5 alarm ignored when disabled", 2'd1, 8'h00);
        drive(1'b1, 2'd0, 8'h08, 4'h0, 1'b0);
        drive(1'b0, 2'd0, 8'h00, 4'h0, 1'b1);
        expect_reg("R5 alarm sets flag", 2'd1, 8'h02);
        check("R6 irq with alarm flag", {7'd0, irq}, 8'h01);
        drive(1'b1, 2'd1, 8'h01, 4'h0, 1'b0);
        expect_reg("R7 zero bit leaves flag", 2'd1, 8'h02);
        drive(1'b1, 2'd1, 8'h02, 4'h0, 1'b0);
        expect_reg("R7 alarm clear", 2'd1, 8'h00);
    endtask

    task automatic test_both();
        drive(1'b1, 2'd0, 8'h0C, 4'h0, 1'b0);
        drive(1'b0, 2'd0, 8'h00, 4'h1, 1'b1);
        expect_reg("R7 both flags", 2'd1, 8'h03);
        drive(1'b1, 2'd1, 8'hFD, 4'h0, 1'b0);
        expect_reg("R7 partial clear", 2'd1, 8'h02);
        check("R6 irq with one flag left", {7'd0, irq}, 8'h01);
        drive(1'b1, 2'd1, 8'h02, 4'h0, 1'b0);
    endtask

    task automatic test_collision();
        drive(1'b1, 2'd0, 8'h0C, 4'h0, 1'b0);
        drive(1'b0, 2'd0, 8'h00, 4'h0, 1'b1);
        drive(1'b1, 2'd1, 8'h02, 4'h0, 1'b1);
        expect_reg("R8 alarm set wins over clear", 2'd1, 8'h02);
        drive(1'b1, 2'd1, 8'h01, 4'h1, 1'b0);
        expect_reg("R8 timer set wins over clear", 2'd1, 8'h03);
        drive(1'b1, 2'd1, 8'h03, 4'h0, 1'b0);
        expect_reg("R8 cleanup", 2'd1, 8'h00);
    endtask

    task automatic test_select_change();
        drive(1'b1, 2'd0, 8'h04, 4'h0, 1'b0);
        drive(1'b1, 2'd0, 8'h05, 4'h1, 1'b0);
        expect_reg("R9 old select seconds used", 2'd1, 8'h01);
        drive(1'b1, 2'd1, 8'h01, 4'h0, 1'b0);
        drive(1'b0, 2'd0, 8'h00, 4'h1, 1'b0);
        expect_reg("R9 seconds ignored after change", 2'd1, 8'h00);
        drive(1'b1, 2'd0, 8'h06, 4'h2, 1'b0);
        expect_reg("R9 old select minutes used", 2'd1, 8'h01);
        drive(1'b1, 2'd1, 8'h01, 4'h0, 1'b0);
        drive(1'b1, 2'd0, 8'h07, 4'h0, 1'b0);
        expect_reg("R9 write alone no event", 2'd1, 8'h00);
        drive(1'b0, 2'd0, 8'h00, 4'h8, 1'b0);
        expect_reg("R9 new select days used", 2'd1, 8'h01);
        drive(1'b1, 2'd1, 8'h01, 4'h0, 1'b0);
    endtask

    task automatic test_unmapped();
        drive(1'b1, 2'd0, 8'h0C, 4'h0, 1'b0);
        drive(1'b0, 2'd0, 8'h00, 4'h0, 1'b1);
        drive(1'b1, 2'd2, 8'hFF, 4'h0, 1'b0);
        drive(1'b1, 2'd3, 8'hFF, 4'h0, 1'b0);
        expect_reg("R10 addr 2 reads zero", 2'd2, 8'h00);
        expect_reg("R10 addr 3 reads zero", 2'd3, 8'h00);
        expect_reg("R10 ctrl untouched", 2'd0, 8'h0C);
        expect_reg("R10 status untouched", 2'd1, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_ctrl_rw();
        test_periodic();
        test_disabled();
        test_alarm();
        test_both();
        test_collision();
        test_select_change();
        test_unmapped();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule